// File: doc/BRIEF.md
# Host Bridge Control Register File

This block holds the control and configuration words of a host bridge as 28 registers of 32 bits each, reached through a simple word bus. The bus has a byte address, a write strobe, write data and read data. Every access moves a full word, and the two low address bits are not used. A read returns the addressed word in the same cycle. A write takes effect at the next rising clock edge.

Most words are plain storage. The interrupt enable word cannot be written directly. Software changes it through two alias words: one sets the bits written as one, the other clears them. The enable word and the status word next to it are read-only.

Bit 2 of the general configuration word works as a reset trigger. When a write moves that bit from 0 to 1, the block sends a reset request to the rest of the chip for one cycle. The written value is stored as usual.

Top module: `hbr_regfile`

## Requirements
- R1: After reset, reads return these values: 0x00=0x00000C40, 0x04=0x00001384, 0x08=0x2BFF8010, 0x0C=0x255E0091, 0x10=0x00006140, 0x1C=0x000001FF, 0x20=0x000001FF, 0x68=0x00000008, 0x6C=0x10000000. Every other word reads zero.
- R2: A write to any plain word is readable in full at the same address from the cycle after the write edge. Reads are combinational on the address.
- R3: A write to the set alias (0x30) stores the value at 0x30. It also ORs the value into the enable word (0x38).
- R4: A write to the clear alias (0x34) stores the value at 0x34. It also clears, in the enable word, every bit written as one.
- R5: Writes to the enable word (0x38) and the status word (0x3C) change nothing. The status word always reads zero.
- R6: A write to 0x04 whose bit 2 is 1 while the stored bit 2 is 0 stores the value. It also drives `rst_req` high for exactly one cycle, starting at that write edge.
- R7: A write to 0x04 that leaves bit 2 at 0, or writes 1 over a stored 1, raises no reset request.
- R8: Byte offsets 0x70 and above are unmapped. Writes to them change no register, and reads of them return zero.
- R9: Address bits [1:0] are ignored, so every access selects the whole word at address bits [ADDR_W-1:2].
- R10: `rst_req` is low during reset and in the first cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Byte address of the accessed word |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the addressed word (combinational) |
| rst_req | output | 1 | One-cycle reset request |

## Verification
Read data comes straight from the stored words, so a wrong word appears on `rd_data` as soon as its address is presented after the faulty edge. An enable word that collects or loses bits wrongly is visible at 0x38 right after the alias write that caused it. A lost or extra reset request shows on `rst_req` in the cycle after the write edge to 0x04. A stored bit 2 that differs from what software expects turns the next 0-to-1 test into a missing or spurious pulse. If unmapped writes alias onto mapped words, the damage shows on a later read of the low word.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned IDX_GENCFG  = 1;
  localparam int unsigned IDX_EN_SET  = 12;
  localparam int unsigned IDX_EN_CLR  = 13;
  localparam int unsigned IDX_EN      = 14;
  localparam int unsigned IDX_STATUS  = 15;
  localparam int unsigned GEN_RST_BIT = 2;

  typedef enum logic [1:0] {KIND_PLAIN, KIND_ENABLE, KIND_STATUS} reg_kind_e;

  function automatic reg_kind_e kind_of(int unsigned idx);
    if (idx == IDX_EN)          return KIND_ENABLE;
    else if (idx == IDX_STATUS) return KIND_STATUS;
    else                        return KIND_PLAIN;
  endfunction

  function automatic logic [WORD_W-1:0] reset_word(int unsigned idx);
    case (idx)
      0:       return 32'h0000_0C40;
      1:       return 32'h0000_1384;
      2:       return 32'h2BFF_8010;
      3:       return 32'h255E_0091;
      4:       return 32'h0000_6140;
      7:       return 32'h0000_01FF;
      8:       return 32'h0000_01FF;
      26:      return 32'h0000_0008;
      27:      return 32'h1000_0000;
      default: return '0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] enable_next(logic [WORD_W-1:0] cur,
                                                    logic [WORD_W-1:0] val,
                                                    logic do_set, logic do_clr);
    if (do_set)      return cur | val;
    else if (do_clr) return cur & ~val;
    else             return cur;
  endfunction

  function automatic logic bit_rises(logic cur, logic nxt);
    return !cur && nxt;
  endfunction
endpackage

// File: rtl/hbr_addr_decode.sv
module hbr_addr_decode #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_REGS = 28,
  localparam int unsigned IDX_W   = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output logic [IDX_W-1:0]  idx,
  output logic              hit,
  output logic              wr_hit
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

  always_comb begin
    idx    = addr[ADDR_W-1:2];
    hit    = (idx <= LAST_IDX);
    wr_hit = wr_en && hit;
  end
endmodule

// File: rtl/hbr_enable_mask.sv
module hbr_enable_mask
  import hbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_wr,
  input  logic              clr_wr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= reset_word(IDX_EN);
    else        en_q <= enable_next(en_q, wdata, set_wr, clr_wr);
  end

  p_enable_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_wr || clr_wr) |=> $stable(en_q));
  p_set_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> ((en_q & $past(wdata)) == $past(wdata)));
  p_clr_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((en_q & $past(wdata)) == '0));
endmodule

// File: rtl/hbr_edge_pulse.sv
module hbr_edge_pulse
  import hbr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic gen_wr,
  input  logic cur_bit,
  input  logic new_bit,
  output logic pulse
);
  logic rise_now;
  assign rise_now = gen_wr && bit_rises(cur_bit, new_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= rise_now;
  end

  p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
  p_pulse_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |-> ($past(gen_wr) && $past(new_bit) && !$past(cur_bit)));
endmodule

// File: rtl/hbr_regfile.sv
module hbr_regfile
  import hbr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_REGS = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              rst_req
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic              hit;
  logic              wr_hit;
  logic [WORD_W-1:0] word_q [NUM_REGS];
  logic [WORD_W-1:0] en_q;
  logic              set_wr, clr_wr, gen_wr;

  hbr_addr_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) dec_i (
    .addr(addr), .wr_en(wr_en), .idx(idx), .hit(hit), .wr_hit(wr_hit)
  );

  assign set_wr = wr_hit && (idx == IDX_W'(IDX_EN_SET));
  assign clr_wr = wr_hit && (idx == IDX_W'(IDX_EN_CLR));
  assign gen_wr = wr_hit && (idx == IDX_W'(IDX_GENCFG));

  hbr_enable_mask mask_i (
    .clk(clk), .rst_n(rst_n), .set_wr(set_wr), .clr_wr(clr_wr),
    .wdata(wr_data), .en_q(en_q)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
    if (kind_of(i) == KIND_ENABLE) begin : g_en
      assign word_q[i] = en_q;
    end else if (kind_of(i) == KIND_STATUS) begin : g_stat
      assign word_q[i] = reset_word(i);
    end else begin : g_plain
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               q <= reset_word(i);
        else if (wr_hit && (idx == IDX_W'(i)))    q <= wr_data;
      end
      assign word_q[i] = q;
    end
  end

  hbr_edge_pulse pulse_i (
    .clk(clk), .rst_n(rst_n), .gen_wr(gen_wr),
    .cur_bit(word_q[IDX_GENCFG][GEN_RST_BIT]),
    .new_bit(wr_data[GEN_RST_BIT]),
    .pulse(rst_req)
  );

  always_comb begin
    rd_data = '0;
    if (hit) rd_data = word_q[idx];
  end

  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (rd_data == '0));
  p_gen_stored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gen_wr |=> (word_q[IDX_GENCFG] == $past(wr_data)));
  p_status_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word_q[IDX_STATUS] == '0);
endmodule

// File: tb/hbr_regfile_tb.sv
module hbr_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        rst_req;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  hbr_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .rst_req(rst_req)
  );

  localparam int NV = 10;
  // write address, write data, read address, expected read, requirement
  localparam logic [7:0]  V_WA [NV] = '{8'h18, 8'h40, 8'h00, 8'h30, 8'h30,
                                        8'h34, 8'h38, 8'h3C, 8'h70, 8'h6E};
  localparam logic [31:0] V_WD [NV] = '{32'hDEADBEEF, 32'h12345678, 32'h11,
                                        32'hF0, 32'hF00, 32'h30, 32'hFFFFFFFF,
                                        32'hFFFFFFFF, 32'hAAAA5555, 32'h1};
  localparam logic [7:0]  V_RA [NV] = '{8'h18, 8'h40, 8'h00, 8'h38, 8'h38,
                                        8'h38, 8'h38, 8'h3C, 8'h00, 8'h6C};
  localparam logic [31:0] V_EX [NV] = '{32'hDEADBEEF, 32'h12345678, 32'h11,
                                        32'hF0, 32'hFF0, 32'hFC0, 32'hFC0,
                                        32'h0, 32'h11, 32'h1};
  // rows: R2, R2, R2, R3, R3, R4, R5, R5, R8, R9
  localparam int V_RQ [NV] = '{2, 2, 2, 3, 3, 4, 5, 5, 8, 9};

  task automatic check(input int rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d actual=%08h expected=%08h", rq, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_chk(input int rq, input logic [7:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    check(rq, rd_data, exp);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    #1;
    check(10, {31'b0, rst_req}, 32'h0);              // R10 during reset
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(10, {31'b0, rst_req}, 32'h0);              // R10 after reset
    // R1 reset values
    read_chk(1, 8'h00, 32'h00000C40);
    read_chk(1, 8'h04, 32'h00001384);
    read_chk(1, 8'h08, 32'h2BFF8010);
    read_chk(1, 8'h0C, 32'h255E0091);
    read_chk(1, 8'h10, 32'h00006140);
    read_chk(1, 8'h1C, 32'h000001FF);
    read_chk(1, 8'h20, 32'h000001FF);
    read_chk(1, 8'h68, 32'h00000008);
    read_chk(1, 8'h6C, 32'h10000000);
    read_chk(1, 8'h38, 32'h0);
    read_chk(1, 8'h44, 32'h0);

    for (int i = 0; i < NV; i++) begin
      do_write(V_WA[i], V_WD[i]);
      read_chk(V_RQ[i], V_RA[i], V_EX[i]);
    end

    // alias words keep the written values: R3, R4
    read_chk(3, 8'h30, 32'hF00);
    read_chk(4, 8'h34, 32'h30);
    // unmapped reads zero: R8
    read_chk(8, 8'h70, 32'h0);
    read_chk(8, 8'hFC, 32'h0);

    // R7: writing bit 2 as 0 gives no pulse
    do_write(8'h04, 32'h00001380);
    check(7, {31'b0, rst_req}, 32'h0);
    read_chk(7, 8'h04, 32'h00001380);
    // R6: rising bit 2 pulses one cycle and stores
    @(negedge clk);
    addr = 8'h04; wr_data = 32'h00001384; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    check(6, {31'b0, rst_req}, 32'h1);
    @(negedge clk);
    check(6, {31'b0, rst_req}, 32'h0);
    read_chk(6, 8'h04, 32'h00001384);
    // R7: writing 1 over 1 gives no pulse
    do_write(8'h04, 32'h00001384);
    check(7, {31'b0, rst_req}, 32'h0);

    summary();
  end
endmodule